// File: doc/BRIEF.md
# Fractional Serial Baud Rate Generator

This block makes the transfer-rate timing for one serial channel. The channel works either as a synchronous shift interface or as an asynchronous UART. A free-running prescaler tick enters the block. An internal divider first reduces it by 2, 8, 32 or 128, chosen by a 2-bit field. A period counter then divides the result by an integer N. In UART mode a phase accumulator can also stretch some periods by one input tick. This gives an average ratio of N + (16-K)/16.

The output is a one-system-clock-wide enable pulse, not a derived clock, so every consumer stays on the system clock. Settings are checked for legality every cycle. An illegal combination stops the pulses at once and sets a sticky error flag. Legal changes are taken up only when the current output period ends, so no period is ever cut short.

Top module: `frac_baud_gen`

## Requirements
- R1: `src_sel` values 0, 1, 2 and 3 make one divider input tick out of 2, 8, 32 and 128 `pre_tick` pulses respectively.
- R2: With a legal plain setting, each output period spans exactly N divider input ticks. A `div_n` field of 0 means N = 16, and any other field value means itself.
- R3: In shift-interface mode (`uart_mode` = 0), N = 1 is legal only while `dbuf_en` = 1. Otherwise it is an illegal setting.
- R4: In shift-interface mode, `frac_en` and `frac_k` have no effect. The divide stays a plain 1/N, and K = 0 raises no error.
- R5: In UART mode with `frac_en` = 0, every N from 1 to 16 is legal, regardless of `dbuf_en`, and gives a plain 1/N.
- R6: In UART mode with `frac_en` = 1, a 4-bit phase starts at 0 and grows by 16-K at the end of each output period. A period that follows a carry out of that phase lasts N+1 input ticks; every other period lasts N. The first period after a start lasts N.
- R7: In UART mode with `frac_en` = 1, N must lie in 2..15 and K in 1..15. Any other value is an illegal setting.
- R8: While `run_en` = 1 and the setting is illegal, no pulse appears and `cfg_err` goes to 1 one cycle later. `cfg_err` stays 1 after the setting is corrected and clears one cycle after `run_en` = 0. After a correction, the first period is a full period counted from the correcting cycle.
- R9: A legal change of N, K, the input select or the mode made in the middle of a period does not alter that period. It applies from the next period on.
- R10: While `run_en` = 0 no pulse appears and all counters clear. The first pulse after `run_en` rises ends exactly one full period of `pre_tick` pulses, counting from the first cycle with `run_en` = 1.
- R11: `baud_pulse` is high for one clock cycle. It rises in the cycle after the edge that takes the `pre_tick` closing a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run enable; low clears counters and the error flag |
| pre_tick | input | 1 | Prescaler tick, one system clock wide |
| uart_mode | input | 1 | 1 = UART mode, 0 = shift-interface mode |
| frac_en | input | 1 | Fractional stretch enable (used in UART mode only) |
| dbuf_en | input | 1 | Double buffering of the channel is on |
| src_sel | input | 2 | Divider input select (/2, /8, /32, /128) |
| div_n | input | 4 | Integer divisor N, where 0 means 16 |
| frac_k | input | 4 | Fraction parameter K |
| baud_pulse | output | 1 | Transfer-rate enable pulse |
| cfg_err | output | 1 | Sticky illegal-setting flag |

## Verification
The assertions expect nothing of `pre_tick` or of the setting inputs. Both may change in any cycle. The only input taken for granted is a reset at the start of the run. The properties on pulse spacing rely on the /2 minimum divide, which makes two pulses in adjacent cycles impossible in any case. The stimulus drives every input shortly after the rising edge, so no value moves at the edge. Random settings are always drawn from the legal ranges of R3, R5 and R7, because the expected pulse intervals are defined only for legal settings. Illegal settings, the range edges and mid-period changes are applied in directed cases instead.

// File: rtl/baud_pkg.sv
// Package: shared widths, the setting record and the divisor decode.
// Assumes: N and K share one field width; the select field picks a power-of-four step.
package baud_pkg;

    localparam int unsigned NF_W  = 4;
    localparam int unsigned SEL_W = 2;

    typedef struct packed {
        logic             uart;
        logic             frac;
        logic [SEL_W-1:0] sel;
        logic [NF_W-1:0]  n;
        logic [NF_W-1:0]  k;
    } baud_cfg_t;

    // Turn the N field into its divisor value; an all-zero field means the top value.
    function automatic logic [NF_W:0] n_value(input logic [NF_W-1:0] f);
        n_value = (f == '0) ? {1'b1, {NF_W{1'b0}}} : {1'b0, f};
    endfunction

endpackage

// File: rtl/baud_cfg_ctl.sv
// Module: setting control. Checks the live setting for legality each cycle,
// keeps the active setting that the counters use, and keeps the sticky error.
// Assumes: wrap marks the last cycle of an output period.
module baud_cfg_ctl
    import baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_en,
    input  logic      dbuf_en,
    input  baud_cfg_t live_cfg,
    input  logic      wrap,
    output baud_cfg_t used_cfg,
    output logic      hold,
    output logic      bad,
    output logic      cfg_err
);

    localparam logic [NF_W:0] N_TOP = {1'b1, {NF_W{1'b0}}};
    localparam logic [NF_W:0] N_TWO = (NF_W+1)'(2);
    localparam logic [NF_W:0] N_ONE = (NF_W+1)'(1);

    logic [NF_W:0] nv;
    baud_cfg_t     act_q;
    logic          fresh_q;

    // Legality of the live setting for its own mode.
    always_comb begin
        nv = n_value(live_cfg.n);
        if (live_cfg.uart && live_cfg.frac)
            bad = (nv < N_TWO) || (nv == N_TOP) || (live_cfg.k == '0);
        else if (!live_cfg.uart)
            bad = (nv == N_ONE) && !dbuf_en;
        else
            bad = 1'b0;
    end

    assign hold     = !run_en || bad;
    assign used_cfg = fresh_q ? live_cfg : act_q;

    // Track whether the counters sit at a fresh start.
    always_ff @(posedge clk) begin
        if (!rst_n)    fresh_q <= 1'b1;
        else if (hold) fresh_q <= 1'b1;
        else           fresh_q <= 1'b0;
    end

    // Capture the live setting at a start or a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                       act_q <= '0;
        else if (hold || fresh_q || wrap) act_q <= live_cfg;
    end

    // Sticky error: set by an illegal run, cleared only by stopping.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_err <= 1'b0;
        else if (!run_en) cfg_err <= 1'b0;
        else if (bad)    cfg_err <= 1'b1;
    end

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cfg_err) |=> cfg_err);
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(bad && run_en));
    a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !cfg_err);

endmodule

// File: rtl/baud_presc.sv
// Module: input-rate select. Counts prescaler ticks and emits one divider tick
// per 2, 8, 32 or 128 of them, chosen by sel.
// Assumes: clear is raised at every start and every period boundary.
module baud_presc #(
    parameter int unsigned SEL_W = baud_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             pre_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             src_tick
);

    localparam int unsigned N_TAPS = 1 << SEL_W;
    localparam int unsigned CNT_W  = 2 * N_TAPS - 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [N_TAPS-1:0] term;

    // One terminal-count detector per select value.
    for (genvar s = 0; s < N_TAPS; s++) begin : g_tap
        assign term[s] = &cnt_q[2*s:0];
    end

    assign src_tick = pre_tick & term[sel];

    // Prescaler tick counter, restarted at each start and boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clear)    cnt_q <= '0;
        else if (pre_tick) cnt_q <= cnt_q + CNT_W'(1);
    end

    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        src_tick |=> !src_tick);

endmodule

// File: rtl/baud_frac_div.sv
// Module: period counter with fractional stretch. Counts divider ticks up to
// N (or N+1 after a phase carry) and registers one pulse per period.
// Assumes: n_field, k_field and frac_on change only at wrap or while hold is high.
module baud_frac_div
    import baud_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            src_tick,
    input  logic [NF_W-1:0] n_field,
    input  logic [NF_W-1:0] k_field,
    input  logic            frac_on,
    output logic            wrap,
    output logic            pulse
);

    localparam int unsigned CW = NF_W + 1;

    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   len;
    logic [NF_W-1:0] acc_q;
    logic            extra_q;
    logic [NF_W-1:0] stepk;
    logic [NF_W:0]   sum;

    assign len   = n_value(n_field) + {{NF_W{1'b0}}, frac_on & extra_q};
    assign wrap  = !hold && src_tick && ((cnt_q + CW'(1)) == len);
    assign stepk = '0 - k_field;
    assign sum   = {1'b0, acc_q} + {1'b0, stepk};

    // Count divider ticks within the period.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (hold)     cnt_q <= '0;
        else if (wrap)     cnt_q <= '0;
        else if (src_tick) cnt_q <= cnt_q + CW'(1);
    end

    // Advance the phase at each boundary; a carry stretches the next period.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            acc_q   <= '0;
            extra_q <= 1'b0;
        end else if (wrap && frac_on) begin
            acc_q   <= sum[NF_W-1:0];
            extra_q <= sum[NF_W];
        end else if (wrap) begin
            acc_q   <= '0;
            extra_q <= 1'b0;
        end
    end

    // Register the enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= wrap;
    end

    a_r11_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    a_r10_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !pulse);
    a_r2_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len);
    a_r6_stretch_only_frac: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !frac_on) |=> !extra_q);

endmodule

// File: rtl/frac_baud_gen.sv
// Module: top of the transfer-rate generator. Joins setting control, input-rate
// select and the period counter; the output is a one-cycle enable pulse.
// Assumes: pre_tick is one system clock wide; rst_n is synchronous.
module frac_baud_gen
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             pre_tick,
    input  logic             uart_mode,
    input  logic             frac_en,
    input  logic             dbuf_en,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [NF_W-1:0]  div_n,
    input  logic [NF_W-1:0]  frac_k,
    output logic             baud_pulse,
    output logic             cfg_err
);

    baud_cfg_t live_cfg;
    baud_cfg_t used_cfg;
    logic      hold;
    logic      bad;
    logic      wrap;
    logic      src_tick;

    assign live_cfg = '{uart: uart_mode, frac: frac_en, sel: src_sel, n: div_n, k: frac_k};

    baud_cfg_ctl u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .dbuf_en  (dbuf_en),
        .live_cfg (live_cfg),
        .wrap     (wrap),
        .used_cfg (used_cfg),
        .hold     (hold),
        .bad      (bad),
        .cfg_err  (cfg_err)
    );

    baud_presc #(.SEL_W(SEL_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hold || wrap),
        .pre_tick (pre_tick),
        .sel      (used_cfg.sel),
        .src_tick (src_tick)
    );

    baud_frac_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .src_tick (src_tick),
        .n_field  (used_cfg.n),
        .k_field  (used_cfg.k),
        .frac_on  (used_cfg.uart && used_cfg.frac),
        .wrap     (wrap),
        .pulse    (baud_pulse)
    );

    a_r8_bad_silent: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> !baud_pulse);
    a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !baud_pulse);

endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       pre_tick = 1'b0;
    logic       uart_mode = 1'b0;
    logic       frac_en = 1'b0;
    logic       dbuf_en = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] div_n = 4'd2;
    logic [3:0] frac_k = 4'd1;
    logic       baud_pulse;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;
    int glen = -1;
    bit got = 0;
    bit done = 0;

    always #5 clk = ~clk;

    frac_baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pre_tick(pre_tick),
        .uart_mode(uart_mode), .frac_en(frac_en), .dbuf_en(dbuf_en),
        .src_sel(src_sel), .div_n(div_n), .frac_k(frac_k),
        .baud_pulse(baud_pulse), .cfg_err(cfg_err)
    );

    function automatic int nval(input int f);
        return (f == 0) ? 16 : f;
    endfunction

    function automatic int dsel(input int s);
        return 2 << (2 * s);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one cycle, then sample just after the edge.
    task automatic step(input logic v);
        pre_tick = v;
        @(posedge clk);
        #1;
        got = 0;
        if (run_en && v) tcnt++;
        if (baud_pulse) begin
            got = 1;
            glen = tcnt;
            tcnt = 0;
        end
    endtask

    task automatic start();
        run_en = 1'b0;
        step(1'b0);
        tcnt = 0;
        run_en = 1'b1;
    endtask

    // Measure nper periods in pre_tick units against the requirement model.
    task automatic measure(input string tag, input int nper, input int d, input int n,
                           input bit frac, input int k, input bit rnd);
        int acc;
        int e;
        acc = 0;
        e = 0;
        for (int j = 0; j < nper; j++) begin
            int exp;
            int guard;
            exp = d * (n + e);
            guard = 0;
            glen = -1;
            do begin
                step(rnd ? (($urandom % 4) != 0) : 1'b1);
                guard++;
            end while (!got && guard < 20000);
            chk(tag, glen, exp);
            if (frac) begin
                acc = acc + 16 - k;
                e = (acc >= 16) ? 1 : 0;
                acc = acc % 16;
            end
        end
    endtask

    task automatic expect_illegal(input string tag);
        int np;
        start();
        np = 0;
        for (int i = 0; i < 60; i++) begin
            step(1'b1);
            if (baud_pulse) np++;
        end
        chk({tag, " no pulse"}, np, 0);
        chk({tag, " cfg_err"}, int'(cfg_err), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) step(1'b0);
        rst_n = 1'b1;
        step(1'b0);
        chk("R10 reset pulse", int'(baud_pulse), 0);
        chk("R8 reset cfg_err", int'(cfg_err), 0);

        // R10: idle produces nothing
        begin
            int np;
            np = 0;
            for (int i = 0; i < 50; i++) begin step(1'b1); if (baud_pulse) np++; end
            chk("R10 idle no pulse", np, 0);
        end

        // R1: each input select, N = 2, shift mode
        for (int s = 0; s < 4; s++) begin
            uart_mode = 0; frac_en = 0; dbuf_en = 0; src_sel = 2'(s); div_n = 4'd2;
            start();
            measure("R1 select", 2, dsel(s), 2, 0, 0, 0);
        end

        // R2: N field 0 means 16, and a mid value
        src_sel = 0; div_n = 4'd0; start();
        measure("R2 n=16", 2, 2, 16, 0, 0, 0);
        div_n = 4'd5; start();
        measure("R2 n=5", 2, 2, 5, 0, 0, 1);

        // R11: N=1 /2 with ticks every cycle gives a pulse every second cycle
        dbuf_en = 1; div_n = 4'd1; start();
        begin
            int np;
            np = 0;
            for (int i = 0; i < 20; i++) begin step(1'b1); if (baud_pulse) np++; end
            chk("R11 one-cycle pulses in 20 cycles", np, 10);
        end

        // R3 and R8: N=1 without double buffering is illegal; correct it
        dbuf_en = 0; div_n = 4'd1; src_sel = 2'd1;
        expect_illegal("R3 n=1 no dbuf");
        tcnt = 0;
        dbuf_en = 1;
        measure("R8 first period after fix", 2, 8, 1, 0, 0, 0);
        chk("R8 err stays after fix", int'(cfg_err), 1);
        run_en = 0;
        step(1'b0);
        chk("R8 err clears on stop", int'(cfg_err), 0);

        // R4: fraction fields ignored in shift mode
        uart_mode = 0; frac_en = 1; frac_k = 4'd0; dbuf_en = 0; src_sel = 0; div_n = 4'd3;
        start();
        measure("R4 plain divide", 3, 2, 3, 0, 0, 0);
        chk("R4 no error", int'(cfg_err), 0);

        // R5: UART plain, N=1 without double buffering is fine
        uart_mode = 1; frac_en = 0; dbuf_en = 0; src_sel = 1; div_n = 4'd1;
        start();
        measure("R5 uart n=1", 2, 8, 1, 0, 0, 0);
        chk("R5 no error", int'(cfg_err), 0);
        div_n = 4'd0; src_sel = 0; start();
        measure("R5 uart n=16", 2, 2, 16, 0, 0, 1);

        // R6: fractional stretch sequences
        uart_mode = 1; frac_en = 1; src_sel = 0; div_n = 4'd3; frac_k = 4'd12;
        start();
        measure("R6 k=12", 9, 2, 3, 1, 12, 0);
        frac_k = 4'd1; start();
        measure("R6 k=1", 6, 2, 3, 1, 1, 1);
        div_n = 4'd15; frac_k = 4'd15; src_sel = 1; start();
        measure("R7 n=15 k=15 legal", 3, 8, 15, 1, 15, 0);
        chk("R7 no error at range edge", int'(cfg_err), 0);

        // R7: illegal fractional settings
        div_n = 4'd0; frac_k = 4'd5; src_sel = 0;
        expect_illegal("R7 n=16");
        div_n = 4'd1;
        expect_illegal("R7 n=1");
        div_n = 4'd4; frac_k = 4'd0;
        expect_illegal("R7 k=0");

        // R9: mid-period change waits for the boundary
        uart_mode = 0; frac_en = 0; dbuf_en = 0; src_sel = 0; div_n = 4'd4;
        start();
        measure("R9 before change", 1, 2, 4, 0, 0, 0);
        step(1'b1); step(1'b1); step(1'b1);
        div_n = 4'd6; src_sel = 2'd1;
        glen = -1;
        begin
            int guard;
            guard = 0;
            do begin step(1'b1); guard++; end while (!got && guard < 2000);
        end
        chk("R9 current period unchanged", glen, 8);
        measure("R9 next period new", 1, 8, 6, 0, 0, 0);

        // Random legal settings
        for (int r = 0; r < 14; r++) begin
            int s;
            int n;
            int k;
            bit u;
            bit f;
            u = $urandom % 2;
            f = u ? $urandom % 2 : 0;
            s = $urandom % 3;
            if (f) begin
                n = 2 + $urandom % 14;
                k = 1 + $urandom % 15;
            end else begin
                n = $urandom % 16;
                k = $urandom % 16;
            end
            uart_mode = u; frac_en = f; src_sel = 2'(s);
            div_n = 4'(n); frac_k = 4'(k);
            dbuf_en = (!u && n == 1) ? 1'b1 : 1'($urandom % 2);
            start();
            measure(f ? "R6 random" : (u ? "R5 random" : "R2 random"),
                    4, dsel(s), nval(n), f, k, 1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule